// File: doc/BRIEF.md
# Boot ROM Access Controller

This block connects a simple internal memory bus to one external PROM or flash device. Each single-word request becomes one timed device cycle. Chip enable is driven low for the programmed number of clocks, together with output enable for a read or write enable for a write. The word address and the write data are held steady for that whole cycle. When the last counted clock closes, read data is captured and the request is acknowledged. A separate configuration port gives software read and write access to two 32-bit control registers.

The timing register holds a 3-bit code that sets the access length. The codes run from 4 to 16 clocks in steps of two, and the all-zero code gives the slowest setting, 18 clocks, so the device is reached safely straight out of reset. The mode register holds a write-open bit and a 2-bit size code. The size code sets how large the addressable window is. Writes while the write-open bit is clear are refused and leave a sticky flag. Requests beyond the window end at once and never touch the device.

Top module: `bootrom_ctl`

## Requirements
- R1: After reset both configuration registers read 0, `dev_ce_n`, `dev_oe_n` and `dev_we_n` are high, and `mem_ack` and `prot_err` are low.
- R2: The access length in clocks is 18 for timing code 0 and 2*code+2 for codes 1 to 7. The timing code is bits 2:0 of the timing register.
- R3: A read inside the window holds `dev_ce_n` and `dev_oe_n` low for exactly the access length while `dev_we_n` stays high. `mem_ack` is high for the one cycle after `dev_ce_n` rises. In that cycle `mem_rdata` equals the `dev_rdata` seen in the last low cycle.
- R4: A write inside the window while the write-open bit (mode register bit 8) is 1 holds `dev_ce_n` and `dev_we_n` low for exactly the access length while `dev_oe_n` stays high. It is then acknowledged the same way as a read, with `mem_rdata` equal to 0.
- R5: A write while the write-open bit is 0 never lowers `dev_ce_n` or `dev_we_n`. It is acknowledged in the cycle after acceptance and sets `prot_err`, which stays high until reset.
- R6: The size code (mode register bits 1:0) sets the window to 4, 8, 1 or 2 times 2^BASE_LOG2 bytes for codes 0, 1, 2 and 3. A byte offset lies inside the window when it is below that size.
- R7: A request outside the window is acknowledged in the cycle after acceptance. It returns `mem_rdata` = 0 and never lowers `dev_ce_n`.
- R8: `dev_addr` equals `mem_addr` shifted right by two, and bits 1:0 of `mem_addr` are ignored. `dev_addr` and `dev_wdata` do not change while `dev_ce_n` is low.
- R9: `cfg_word` = 0 selects the mode register and 1 selects the timing register. Unused bits (mode bits 31:9 and 7:2, timing bits 31:3) read 0 whatever is written. `cfg_rdata` follows `cfg_word` in the same cycle, and a write takes effect at the clock edge.
- R10: A configuration write made while a device access is running leaves that access's length unchanged and applies from the next access.
- R11: A request is held until `mem_ack`. `mem_ack` is a one-cycle pulse, and a request still present in its ack cycle is not accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_word | input | 1 | Register select: 0 mode, 1 timing |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected register contents |
| mem_req | input | 1 | Memory request, held until acknowledged |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | ADDR_W | Byte offset into the device window |
| mem_wdata | input | DATA_W | Write data |
| mem_ack | output | 1 | One-cycle completion pulse |
| mem_rdata | output | DATA_W | Read data, valid with `mem_ack` |
| prot_err | output | 1 | Sticky refused-write flag |
| dev_ce_n | output | 1 | Device chip enable, active low |
| dev_oe_n | output | 1 | Device output enable, active low |
| dev_we_n | output | 1 | Device write enable, active low |
| dev_addr | output | ADDR_W-2 | Device word address |
| dev_wdata | output | DATA_W | Device write data |
| dev_rdata | input | DATA_W | Device read data |

## Verification
The bench builds the block with ADDR_W = 12 and BASE_LOG2 = 7. The four windows then become 512, 1024, 128 and 256 bytes inside a 4096-byte offset space. This puts the edge of every size code, and the addresses beyond it, within reach of both directed and random offsets. All eight timing codes are measured directly, and random configurations mix reads, open writes, refused writes and out-of-window requests. One directed case rewrites the timing register partway through an access.

// File: rtl/bootrom_pkg.sv
package bootrom_pkg;

    localparam int REG_W    = 32;
    localparam int MASK_BIT = 8;
    localparam int CNT_W    = 5;

    typedef enum logic {
        ST_IDLE,
        ST_BUSY
    } seq_state_e;

    // Non-linear access length: code 0 is the slowest (reset-safe) setting.
    function automatic logic [CNT_W-1:0] access_len(input logic [2:0] code);
        logic [CNT_W-1:0] len;
        if (code == 3'd0) begin
            len = CNT_W'(18);
        end else begin
            len = {1'b0, code, 1'b0} + CNT_W'(2);
        end
        return len;
    endfunction

endpackage

// File: rtl/bootrom_regs.sv
module bootrom_regs
    import bootrom_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_word,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             wr_open,
    output logic [1:0]       size_code,
    output logic [2:0]       time_code
);

    typedef struct packed {
        logic       open;
        logic [1:0] size;
        logic [2:0] tcode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Bits with no storage behind them are simply dropped on write.
    logic unused_wbits;
    assign unused_wbits = ^{cfg_wdata[REG_W-1:MASK_BIT+1], cfg_wdata[MASK_BIT-1:3]};

    always_comb begin
        cfg_d     = cfg_q;
        cfg_rdata = '0;
        if (cfg_we) begin
            if (cfg_word) begin
                cfg_d.tcode = cfg_wdata[2:0];
            end else begin
                cfg_d.open = cfg_wdata[MASK_BIT];
                cfg_d.size = cfg_wdata[1:0];
            end
        end
        if (cfg_word) begin
            cfg_rdata[2:0] = cfg_q.tcode;
        end else begin
            cfg_rdata[MASK_BIT] = cfg_q.open;
            cfg_rdata[1:0]      = cfg_q.size;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign wr_open   = cfg_q.open;
    assign size_code = cfg_q.size;
    assign time_code = cfg_q.tcode;

    AST_TCODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_we) |-> $stable(time_code)); // R9

endmodule

// File: rtl/bootrom_window.sv
module bootrom_window #(
    parameter int ADDR_W    = 24,
    parameter int BASE_LOG2 = 20
) (
    input  logic [ADDR_W-1:0] byte_off,
    input  logic [1:0]        size_code,
    output logic              in_win
);

    logic [3:0] fits;

    // Size code order is not monotonic: the exponent offset is code ^ 2.
    for (genvar i = 0; i < 4; i++) begin : g_size
        localparam int LG = BASE_LOG2 + (i ^ 2);
        assign fits[i] = ((byte_off >> LG) == '0);
    end

    assign in_win = fits[size_code];

endmodule

// File: rtl/bootrom_seq.sv
module bootrom_seq
    import bootrom_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    input  logic              in_win,
    input  logic              wr_open,
    input  logic [2:0]        time_code,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              mem_ack,
    output logic [DATA_W-1:0] mem_rdata,
    output logic              prot_err,
    output logic              dev_ce_n,
    output logic              dev_oe_n,
    output logic              dev_we_n,
    output logic [ADDR_W-3:0] dev_addr,
    output logic [DATA_W-1:0] dev_wdata
);

    localparam int DEV_AW = ADDR_W - 2;

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic [DEV_AW-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ack;
        logic [DATA_W-1:0] rdata;
        logic              prot;
    } seq_t;

    seq_t s_d, s_q;

    logic unused_lsbs;
    assign unused_lsbs = ^mem_addr[1:0];

    always_comb begin
        s_d     = s_q;
        s_d.ack = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (mem_req && !s_q.ack) begin
                    if (mem_we && !wr_open) begin
                        s_d.ack   = 1'b1;
                        s_d.rdata = '0;
                        s_d.prot  = 1'b1;
                    end else if (!in_win) begin
                        s_d.ack   = 1'b1;
                        s_d.rdata = '0;
                    end else begin
                        s_d.st    = ST_BUSY;
                        s_d.cnt   = access_len(time_code) - CNT_W'(1);
                        s_d.ce_n  = 1'b0;
                        s_d.oe_n  = mem_we;
                        s_d.we_n  = !mem_we;
                        s_d.addr  = mem_addr[ADDR_W-1:2];
                        s_d.wdata = mem_wdata;
                    end
                end
            end
            ST_BUSY: begin
                if (s_q.cnt == '0) begin
                    s_d.st    = ST_IDLE;
                    s_d.ce_n  = 1'b1;
                    s_d.oe_n  = 1'b1;
                    s_d.we_n  = 1'b1;
                    s_d.ack   = 1'b1;
                    s_d.rdata = s_q.oe_n ? '0 : dev_rdata;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_IDLE;
            s_q.ce_n  <= 1'b1;
            s_q.oe_n  <= 1'b1;
            s_q.we_n  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_ack   = s_q.ack;
    assign mem_rdata = s_q.rdata;
    assign prot_err  = s_q.prot;
    assign dev_ce_n  = s_q.ce_n;
    assign dev_oe_n  = s_q.oe_n;
    assign dev_we_n  = s_q.we_n;
    assign dev_addr  = s_q.addr;
    assign dev_wdata = s_q.wdata;

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ack |=> !mem_ack); // R11

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_ce_n && $past(!dev_ce_n)) |-> ($stable(dev_addr) && $stable(dev_wdata))); // R8

    AST_WE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_we_n) |-> $past(wr_open)); // R4

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dev_oe_n && !dev_we_n)); // R3

    AST_PROT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |=> prot_err); // R5

    AST_CE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_ce_n) |-> $past(in_win)); // R7

endmodule

// File: rtl/bootrom_ctl.sv
module bootrom_ctl
    import bootrom_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int BASE_LOG2 = 20,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_word,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic              mem_ack,
    output logic [DATA_W-1:0] mem_rdata,
    output logic              prot_err,
    output logic              dev_ce_n,
    output logic              dev_oe_n,
    output logic              dev_we_n,
    output logic [ADDR_W-3:0] dev_addr,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata
);

    logic       wr_open;
    logic [1:0] size_code;
    logic [2:0] time_code;
    logic       in_win;

    bootrom_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_word  (cfg_word),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .wr_open   (wr_open),
        .size_code (size_code),
        .time_code (time_code)
    );

    bootrom_window #(
        .ADDR_W    (ADDR_W),
        .BASE_LOG2 (BASE_LOG2)
    ) u_window (
        .byte_off  (mem_addr),
        .size_code (size_code),
        .in_win    (in_win)
    );

    bootrom_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .in_win    (in_win),
        .wr_open   (wr_open),
        .time_code (time_code),
        .dev_rdata (dev_rdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .prot_err  (prot_err),
        .dev_ce_n  (dev_ce_n),
        .dev_oe_n  (dev_oe_n),
        .dev_we_n  (dev_we_n),
        .dev_addr  (dev_addr),
        .dev_wdata (dev_wdata)
    );

endmodule

// File: tb/bootrom_ctl_bench.sv
`timescale 1ns/1ps
module bootrom_ctl_bench;

    localparam int AW  = 12;
    localparam int BL  = 7;
    localparam int DW  = 32;
    localparam int DAW = AW - 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_word = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          mem_req = 1'b0;
    logic          mem_we = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [DW-1:0] mem_wdata = '0;
    logic          mem_ack;
    logic [DW-1:0] mem_rdata;
    logic          prot_err;
    logic          dev_ce_n, dev_oe_n, dev_we_n;
    logic [DAW-1:0] dev_addr;
    logic [DW-1:0] dev_wdata;
    logic [DW-1:0] dev_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model of the programmed configuration
    logic       m_open = 1'b0;
    logic [1:0] m_size = 2'd0;
    logic [2:0] m_tcode = 3'd0;
    logic       m_prot = 1'b0;

    always #10 clk = ~clk;

    assign dev_rdata = 32'h5A00_0000 | 32'(dev_addr);

    bootrom_ctl #(.ADDR_W(AW), .BASE_LOG2(BL), .DATA_W(DW)) u_bootrom_ctl (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_word(cfg_word), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .prot_err(prot_err),
        .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n), .dev_we_n(dev_we_n),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    function automatic int exp_len(input logic [2:0] c);
        return (c == 3'd0) ? 18 : 2 * int'(c) + 2;
    endfunction

    function automatic bit exp_inwin(input logic [AW-1:0] a, input logic [1:0] sz);
        int lim;
        lim = 1 << (BL + int'(sz ^ 2'b10));
        return int'(a) < lim;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic word, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_word = word; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        if (word) m_tcode = val[2:0];
        else begin m_open = val[8]; m_size = val[1:0]; end
    endtask

    task automatic cfg_read(input logic word, output logic [31:0] val);
        @(negedge clk);
        cfg_word = word;
        #1;
        val = cfg_rdata;
    endtask

    // One memory request; checks device-side behaviour against the model.
    task automatic run_access(input logic we, input logic [AW-1:0] addr,
                              input logic [31:0] wd, input int mid_code, input string tag);
        int n, ce_cyc, exp_n, exp_c;
        bit done, sig_bad, we_seen;
        logic [31:0] rd, exp_rd;
        bit dev_go;
        dev_go = (!we || m_open) && exp_inwin(addr, m_size);
        exp_c  = dev_go ? exp_len(m_tcode) : 0;
        exp_n  = exp_c + 1;
        exp_rd = (dev_go && !we) ? (32'h5A00_0000 | 32'(addr >> 2)) : 32'h0;
        if (we && !m_open) m_prot = 1'b1;
        @(negedge clk);
        mem_req = 1'b1; mem_we = we; mem_addr = addr; mem_wdata = wd;
        n = 0; ce_cyc = 0; done = 0; sig_bad = 0; we_seen = 0; rd = '0;
        while (!done) begin
            @(negedge clk);
            n++;
            if (mid_code >= 0 && n == 2) begin
                cfg_we = 1'b1; cfg_word = 1'b1; cfg_wdata = 32'(mid_code);
            end else begin
                cfg_we = 1'b0;
            end
            if (!dev_we_n) we_seen = 1;
            if (!dev_ce_n) begin
                ce_cyc++;
                if (dev_addr != DAW'(addr >> 2)) sig_bad = 1;
                if (dev_oe_n != we || dev_we_n != !we) sig_bad = 1;
                if (we && dev_wdata != wd) sig_bad = 1;
            end
            if (mem_ack) begin
                done = 1; rd = mem_rdata; mem_req = 1'b0;
            end
            if (n > 200) begin
                done = 1;
                chk(0, "R11", {tag, " no ack"}, 32'(n), 32'(exp_n));
            end
        end
        cfg_we = 1'b0;
        if (mid_code >= 0) m_tcode = 3'(mid_code);
        chk(ce_cyc == exp_c, dev_go ? (we ? "R4" : "R3") : (we ? "R5" : "R7"),
            {tag, " ce cycles (R2)"}, 32'(ce_cyc), 32'(exp_c));
        chk(n == exp_n, "R11", {tag, " ack latency"}, 32'(n), 32'(exp_n));
        chk(rd == exp_rd, we ? "R4" : "R3", {tag, " rdata"}, rd, exp_rd);
        chk(!sig_bad, "R8", {tag, " device pins"}, 32'(sig_bad), 32'h0);
        chk(we_seen == (dev_go && we), "R5", {tag, " we_n activity"}, 32'(we_seen), 32'(dev_go && we));
        @(negedge clk);
        chk(!mem_ack, "R11", {tag, " ack pulse width"}, 32'(mem_ack), 32'h0);
        chk(prot_err == m_prot, "R5", {tag, " prot_err"}, 32'(prot_err), 32'(m_prot));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cfg_read(1'b0, v); chk(v == 0, "R1", "mode after reset", v, 0);
        cfg_read(1'b1, v); chk(v == 0, "R1", "timing after reset", v, 0);
        chk({dev_ce_n, dev_oe_n, dev_we_n} == 3'b111, "R1", "device pins idle",
            32'({dev_ce_n, dev_oe_n, dev_we_n}), 32'h7);
        chk(!mem_ack && !prot_err, "R1", "ack/prot idle", 32'({mem_ack, prot_err}), 0);

        // R2 default 18-clock read straight out of reset
        run_access(1'b0, 12'h010, 32'h0, -1, "reset read");

        // R9 register field masks
        cfg_write(1'b0, 32'hFFFF_FFFF);
        cfg_read(1'b0, v); chk(v == 32'h103, "R9", "mode reserved bits", v, 32'h103);
        cfg_write(1'b1, 32'hFFFF_FFF8);
        cfg_read(1'b1, v); chk(v == 32'h0, "R9", "timing reserved bits", v, 0);
        cfg_read(1'b0, v); chk(v == 32'h103, "R9", "mode unaffected", v, 32'h103);

        // R2 all timing codes, read and open write
        for (int c = 0; c < 8; c++) begin
            cfg_write(1'b1, 32'(c));
            run_access(1'b0, 12'h024 | 12'(c), 32'h0, -1, "code read");
            run_access(1'b1, 12'h040, 32'hCAFE_0000 | 32'(c), -1, "code write");
        end

        // R6/R7 window edges for every size code
        for (int s = 0; s < 4; s++) begin
            int lim;
            cfg_write(1'b0, 32'h100 | 32'(s));
            cfg_write(1'b1, 32'h1);
            lim = 1 << (BL + (s ^ 2));
            run_access(1'b0, 12'(lim - 1), 32'h0, -1, "R6 last byte");
            run_access(1'b0, 12'(lim), 32'h0, -1, "R7 first outside");
            run_access(1'b1, 12'(lim + 4), 32'h1234, -1, "R7 write outside");
        end

        // R10 timing change mid-access
        cfg_write(1'b0, 32'h100);
        cfg_write(1'b1, 32'h1);
        run_access(1'b0, 12'h008, 32'h0, 7, "R10 during");
        run_access(1'b0, 12'h00C, 32'h0, -1, "R10 next");

        // R5 refused write, then sticky
        cfg_write(1'b0, 32'h0);
        run_access(1'b1, 12'h004, 32'hDEAD_BEEF, -1, "R5 masked");
        cfg_write(1'b0, 32'h100);
        run_access(1'b1, 12'h004, 32'h1111_2222, -1, "R5 after open");

        // random mix
        for (int i = 0; i < 80; i++) begin
            cfg_write(1'b1, $urandom());
            cfg_write(1'b0, $urandom());
            run_access(1'($urandom_range(0, 1)), 12'($urandom_range(0, 4095)),
                       $urandom(), -1, "random");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule